// File: doc/BRIEF.md
# Host Remote DMA Data Port

This block lets a host processor reach packet memory through one data-port register. It does not need to address every byte of that memory. The host sets a starting address and a byte count through small configuration registers. Each later read or write of the data port then moves one byte, or one 16-bit word, between the port and the internal packet SRAM. After each transfer the address steps forward and the count steps down. When the count runs out, a ready flag is raised and further data-port accesses are ignored.

Reads are served from a prefetch register that is refilled every cycle from the next location. Data is therefore valid as soon as the host strobes the port, and reads may follow one another on every clock. Writes that step into the page where the receive area begins are folded back to the first SRAM page. The transmit area below the receive area thus behaves as a ring. The current address can be read back one byte at a time.

Top module: `rdma_port`

## Requirements
- R1: After reset the current address is 0000h, the byte count is zero and `dma_ready` is low.
- R2: A write with `host_sel`=0 or 1 replaces bits [7:0] or bits [15:8] of the current address with `host_wdata[7:0]`. Reading those selects returns the same address byte on `host_rdata[7:0]`, with the upper 8 bits zero.
- R3: A write with `host_sel`=2 or 3 loads bits [7:0] or bits [15:8] of the byte count from `host_wdata[7:0]`. From the next cycle `dma_ready` is low.
- R4: In byte mode (`word_mode`=0), a data-port write (`host_sel`=4) with a nonzero count stores `host_wdata[7:0]` at the current address. It advances the address by 1 and lowers the count by 1.
- R5: In word mode, a data-port write stores `host_wdata[7:0]` at the current address and `host_wdata[15:8]` at the next address. It advances the address by 2 and lowers the count by 2. A count of 1 drops to zero.
- R6: During a data-port read, `host_rdata` already holds the data for the current address in the same cycle. In byte mode this is the byte in [7:0] with [15:8] zero. In word mode it is {byte at address+1, byte at address}. Reads step the address and count as writes do, and may occur on consecutive cycles.
- R7: `dma_ready` rises in the cycle after the data-port access that brings the count to zero.
- R8: While the count is zero, a data-port access leaves the SRAM, the address and the count unchanged.
- R9: When a data-port write steps the address into page `rx_page_start`, the address becomes page BASE_PAGE (default 40h) with the same low byte. Reads never fold the address.
- R10: The SRAM spans pages BASE_PAGE to BASE_PAGE+NUM_PAGES-1 (default 40h to 47h). Writes outside that span are dropped and reads outside it return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_mode | input | 1 | 1: 16-bit data-port transfers, 0: 8-bit |
| rx_page_start | input | 8 | First page of the receive area; transmit writes fold below it |
| host_sel | input | 3 | Register select: 0 addr low, 1 addr high, 2 count low, 3 count high, 4 data port |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for the selected register |
| dma_ready | output | 1 | Set when the byte count has run out, cleared by a count write |

## Verification
On every cycle the assertions check four things. The count falls on each live transfer. A run-out count freezes the address and the count. The ready flag rises only on a transfer that empties the count, and it drops after a count write. A write step never lands on the receive start page. What the bench scenarios alone can show is the data itself. This covers lane order in word mode, the prefetch on back-to-back reads, folded writes at the page boundary and the reads that do not fold, and the dropped writes outside the SRAM span and after the count has run out.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

  typedef enum logic [2:0] {
    SEL_ADDR_LO = 3'd0,
    SEL_ADDR_HI = 3'd1,
    SEL_CNT_LO  = 3'd2,
    SEL_CNT_HI  = 3'd3,
    SEL_DATA    = 3'd4
  } host_sel_e;

  // Address after one data-port transfer; writes fold at the receive start page.
  function automatic logic [15:0] step_addr(input logic [15:0] addr,
                                            input logic        word,
                                            input logic        is_wr,
                                            input logic [7:0]  rx_start,
                                            input logic [7:0]  base_page);
    logic [15:0] nxt;
    nxt = addr + (word ? 16'd2 : 16'd1);
    if (is_wr && (nxt[15:8] == rx_start))
      nxt = {base_page, nxt[7:0]};
    return nxt;
  endfunction

  // Remaining byte count after one transfer, saturating at zero.
  function automatic logic [15:0] step_count(input logic [15:0] cnt,
                                             input logic        word);
    logic [15:0] dec;
    dec = word ? 16'd2 : 16'd1;
    return (cnt <= dec) ? 16'd0 : (cnt - dec);
  endfunction

  // True when the page of addr lies in [base_page, base_page+pages).
  function automatic logic in_window(input logic [15:0] addr,
                                     input logic [7:0]  base_page,
                                     input int          pages);
    int pg;
    pg = int'(addr[15:8]);
    return (pg >= int'(base_page)) && (pg < int'(base_page) + pages);
  endfunction

endpackage

// File: rtl/rdma_regs.sv
module rdma_regs
  import rdma_pkg::*;
#(
  parameter logic [7:0] BASE_PAGE = 8'h40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        word_mode,
  input  logic [7:0]  rx_page_start,
  input  logic [2:0]  host_sel,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [7:0]  host_wbyte,
  output logic [15:0] cur_addr,
  output logic [15:0] addr_nxt,
  output logic [15:0] byte_cnt,
  output logic        ready,
  output logic        xfer_fire,
  output logic        xfer_write
);

  host_sel_e sel_e;
  logic      data_acc;
  logic      cnt_wr;
  logic [15:0] cnt_nxt;
  logic      ready_nxt;

  assign sel_e      = host_sel_e'(host_sel);
  assign data_acc   = (sel_e == SEL_DATA) && (host_wr || host_rd);
  assign xfer_fire  = data_acc && (byte_cnt != 16'd0);
  assign xfer_write = xfer_fire && host_wr;
  assign cnt_wr     = host_wr && ((sel_e == SEL_CNT_LO) || (sel_e == SEL_CNT_HI));

  always_comb begin
    addr_nxt = cur_addr;
    if (host_wr && sel_e == SEL_ADDR_LO)
      addr_nxt = {cur_addr[15:8], host_wbyte};
    else if (host_wr && sel_e == SEL_ADDR_HI)
      addr_nxt = {host_wbyte, cur_addr[7:0]};
    else if (xfer_fire)
      addr_nxt = step_addr(cur_addr, word_mode, host_wr, rx_page_start, BASE_PAGE);
  end

  always_comb begin
    cnt_nxt   = byte_cnt;
    ready_nxt = ready;
    if (host_wr && sel_e == SEL_CNT_LO) begin
      cnt_nxt   = {byte_cnt[15:8], host_wbyte};
      ready_nxt = 1'b0;
    end else if (host_wr && sel_e == SEL_CNT_HI) begin
      cnt_nxt   = {host_wbyte, byte_cnt[7:0]};
      ready_nxt = 1'b0;
    end else if (xfer_fire) begin
      cnt_nxt = step_count(byte_cnt, word_mode);
      if (cnt_nxt == 16'd0) ready_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= 16'd0;
      byte_cnt <= 16'd0;
      ready    <= 1'b0;
    end else begin
      cur_addr <= addr_nxt;
      byte_cnt <= cnt_nxt;
      ready    <= ready_nxt;
    end
  end

  // R4/R5: every live transfer lowers the remaining count
  p_count_falls_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_fire |=> byte_cnt < $past(byte_cnt));

  // R8: with the count run out, the address and count do not move
  p_zero_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && byte_cnt == 16'd0) |=> ($stable(cur_addr) && byte_cnt == 16'd0));

  // R7: the ready flag only rises on a transfer that empties the count
  p_ready_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (byte_cnt == 16'd0 && $past(xfer_fire)));

  // R3: a count write drops the ready flag
  p_ready_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> !ready);

  // R9: a write step never leaves the address on the receive start page
  p_fold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_write |=> cur_addr[15:8] != $past(rx_page_start));

endmodule

// File: rtl/rdma_sram.sv
module rdma_sram
  import rdma_pkg::*;
#(
  parameter logic [7:0] BASE_PAGE = 8'h40,
  parameter int         NUM_PAGES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        word_mode,
  input  logic        wr_en,
  input  logic [15:0] wr_addr,
  input  logic [15:0] wr_data,
  input  logic [15:0] rd_addr,
  output logic [15:0] rd_data
);

  localparam int LANES     = 2;
  localparam int MEM_BYTES = NUM_PAGES * 256;
  localparam int IDX_W     = $clog2(MEM_BYTES);
  localparam logic [15:0] BASE_ADDR = {BASE_PAGE, 8'h00};

  logic [7:0] mem [MEM_BYTES];
  logic [LANES-1:0][7:0] rd_q;

  logic [15:0]      wr_lane_addr [LANES];
  logic [15:0]      rd_lane_addr [LANES];
  logic [IDX_W-1:0] wr_idx [LANES];
  logic [IDX_W-1:0] rd_idx [LANES];
  logic [LANES-1:0] wr_ok;
  logic [LANES-1:0] rd_ok;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wr_lane_addr[g] = wr_addr + 16'(g);
    assign rd_lane_addr[g] = rd_addr + 16'(g);
    assign wr_idx[g] = IDX_W'(wr_lane_addr[g] - BASE_ADDR);
    assign rd_idx[g] = IDX_W'(rd_lane_addr[g] - BASE_ADDR);
    assign wr_ok[g]  = wr_en && (g == 0 || word_mode) &&
                       in_window(wr_lane_addr[g], BASE_PAGE, NUM_PAGES);
    assign rd_ok[g]  = in_window(rd_lane_addr[g], BASE_PAGE, NUM_PAGES);
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++)
      if (wr_ok[l]) mem[wr_idx[l]] <= wr_data[8*l +: 8];
  end

  // Prefetch: the location the address will hold next cycle is loaded now.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else begin
      for (int l = 0; l < LANES; l++)
        rd_q[l] <= rd_ok[l] ? mem[rd_idx[l]] : 8'h00;
    end
  end

  assign rd_data = {rd_q[1], rd_q[0]};

endmodule

// File: rtl/rdma_port.sv
module rdma_port
  import rdma_pkg::*;
#(
  parameter logic [7:0] BASE_PAGE = 8'h40,
  parameter int         NUM_PAGES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        word_mode,
  input  logic [7:0]  rx_page_start,
  input  logic [2:0]  host_sel,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  output logic        dma_ready
);

  logic [15:0] cur_addr;
  logic [15:0] addr_nxt;
  logic [15:0] byte_cnt;
  logic        xfer_fire;
  logic        xfer_write;
  logic [15:0] pf_data;
  host_sel_e   sel_e;

  assign sel_e = host_sel_e'(host_sel);

  rdma_regs #(.BASE_PAGE(BASE_PAGE)) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .word_mode     (word_mode),
    .rx_page_start (rx_page_start),
    .host_sel      (host_sel),
    .host_wr       (host_wr),
    .host_rd       (host_rd),
    .host_wbyte    (host_wdata[7:0]),
    .cur_addr      (cur_addr),
    .addr_nxt      (addr_nxt),
    .byte_cnt      (byte_cnt),
    .ready         (dma_ready),
    .xfer_fire     (xfer_fire),
    .xfer_write    (xfer_write)
  );

  rdma_sram #(.BASE_PAGE(BASE_PAGE), .NUM_PAGES(NUM_PAGES)) u_sram (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_mode (word_mode),
    .wr_en     (xfer_write),
    .wr_addr   (cur_addr),
    .wr_data   (host_wdata),
    .rd_addr   (addr_nxt),
    .rd_data   (pf_data)
  );

  always_comb begin
    case (sel_e)
      SEL_ADDR_LO: host_rdata = {8'h00, cur_addr[7:0]};
      SEL_ADDR_HI: host_rdata = {8'h00, cur_addr[15:8]};
      SEL_DATA:    host_rdata = word_mode ? pf_data : {8'h00, pf_data[7:0]};
      default:     host_rdata = 16'h0000;
    endcase
  end

  // R1: flag is low straight out of reset
  p_reset_flag_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> !dma_ready);

endmodule

// File: tb/tb_rdma_port.sv
module tb_rdma_port;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_mode = 1'b0;
  logic [7:0]  rx_page_start = 8'h42;
  logic [2:0]  host_sel = 3'd0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [15:0] host_wdata = 16'h0;
  logic [15:0] host_rdata;
  logic        dma_ready;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #(PERIOD/2) clk = ~clk;

  rdma_port dut (
    .clk(clk), .rst_n(rst_n), .word_mode(word_mode), .rx_page_start(rx_page_start),
    .host_sel(host_sel), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .dma_ready(dma_ready)
  );

  // Monitor: compares every strobed read against the scoreboard queue.
  initial begin
    forever begin
      @(negedge clk);
      #(PERIOD/4);
      if (host_rd && exp_q.size() > 0) begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        compared++;
        if (host_rdata !== e) begin
          mismatched++;
          $display("FAIL %s actual=%h expected=%h", t, host_rdata, e);
        end
      end
    end
  end

  task automatic idle();
    @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b0;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [15:0] d);
    @(negedge clk);
    host_sel = sel; host_wdata = d; host_wr = 1'b1; host_rd = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, input logic [15:0] e, input string t);
    @(negedge clk);
    host_sel = sel; host_wr = 1'b0; host_rd = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic set_addr(input logic [15:0] a);
    wr(3'd0, {8'h00, a[7:0]});
    wr(3'd1, {8'h00, a[15:8]});
  endtask

  task automatic set_cnt(input logic [15:0] c);
    wr(3'd2, {8'h00, c[7:0]});
    wr(3'd3, {8'h00, c[15:8]});
  endtask

  task automatic chk_addr(input logic [15:0] a, input string t);
    rd(3'd0, {8'h00, a[7:0]}, t);
    rd(3'd1, {8'h00, a[15:8]}, t);
    idle();
  endtask

  task automatic chk_ready(input logic e, input string t);
    @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b0;
    #(PERIOD/4);
    compared++;
    if (dma_ready !== e) begin
      mismatched++;
      $display("FAIL %s actual=%b expected=%b", t, dma_ready, e);
    end
  endtask

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk_ready(1'b0, "R1 ready after reset");
    chk_addr(16'h0000, "R1 address after reset");

    // R2, R3, R4, R6 byte-mode writes then back-to-back reads
    set_addr(16'h4010);
    chk_addr(16'h4010, "R2 address readback");
    set_cnt(16'd4);
    chk_ready(1'b0, "R3 ready cleared by count write");
    wr(3'd4, 16'h00AA); wr(3'd4, 16'h00BB); wr(3'd4, 16'h00CC);
    chk_ready(1'b0, "R7 ready still low with one byte left");
    wr(3'd4, 16'h00DD);
    chk_ready(1'b1, "R7 ready after count reaches zero");
    chk_addr(16'h4014, "R4 address after four byte writes");
    set_addr(16'h4010); set_cnt(16'd4);
    rd(3'd4, 16'h00AA, "R6 byte read 0");
    rd(3'd4, 16'h00BB, "R6 byte read 1");
    rd(3'd4, 16'h00CC, "R6 byte read 2");
    rd(3'd4, 16'h00DD, "R6 byte read 3");
    idle();
    chk_ready(1'b1, "R7 ready after reads empty count");

    // R8 access with zero count is dropped
    set_addr(16'h4014); set_cnt(16'd1);
    wr(3'd4, 16'h0011);
    wr(3'd4, 16'h0077);
    chk_addr(16'h4015, "R8 address frozen at zero count");
    set_addr(16'h4014); set_cnt(16'd1);
    rd(3'd4, 16'h0011, "R8 dropped write left SRAM intact");
    idle();

    // R3 count write clears a set flag
    set_cnt(16'd2);
    chk_ready(1'b0, "R3 ready cleared after being set");

    // R5 word-mode writes and lane order
    word_mode = 1'b1;
    set_addr(16'h4100); set_cnt(16'd6);
    wr(3'd4, 16'h2211); wr(3'd4, 16'h4433); wr(3'd4, 16'h6655);
    chk_ready(1'b1, "R7 ready after three word writes");
    chk_addr(16'h4106, "R5 address advanced by two per word");
    set_addr(16'h4100); set_cnt(16'd6);
    rd(3'd4, 16'h2211, "R6 word read 0");
    rd(3'd4, 16'h4433, "R6 word read 1");
    rd(3'd4, 16'h6655, "R6 word read 2");
    idle();
    word_mode = 1'b0;
    set_addr(16'h4101); set_cnt(16'd2);
    rd(3'd4, 16'h0022, "R5 high lane at odd address");
    rd(3'd4, 16'h0033, "R5 low lane at next even address");
    idle();

    // R5 odd count saturates in word mode
    word_mode = 1'b1;
    set_addr(16'h4300); set_cnt(16'd3);
    wr(3'd4, 16'h0101);
    chk_ready(1'b0, "R5 count 3 leaves one byte");
    wr(3'd4, 16'h0202);
    chk_ready(1'b1, "R5 count 1 drops to zero on a word");
    wr(3'd4, 16'h0303);
    chk_addr(16'h4304, "R8 word write after zero count dropped");

    // R9 writes fold at the receive start page
    set_addr(16'h41FE); set_cnt(16'd4);
    wr(3'd4, 16'hA1B2); wr(3'd4, 16'hC3D4);
    chk_addr(16'h4002, "R9 write address folded to base page");
    set_addr(16'h4000); set_cnt(16'd2);
    rd(3'd4, 16'hC3D4, "R9 folded word stored at base page");
    idle();
    set_addr(16'h41FE); set_cnt(16'd2);
    rd(3'd4, 16'hA1B2, "R9 word before fold");
    idle();
    word_mode = 1'b0;
    set_addr(16'h41FF); set_cnt(16'd1);
    rd(3'd4, 16'h00A1, "R9 byte read at last transmit byte");
    idle();
    chk_addr(16'h4200, "R9 reads do not fold");

    // R10 outside the SRAM span
    set_addr(16'h3000); set_cnt(16'd1);
    wr(3'd4, 16'h0099);
    set_addr(16'h3000); set_cnt(16'd1);
    rd(3'd4, 16'h0000, "R10 write below span dropped, read zero");
    idle();
    set_addr(16'h4800); set_cnt(16'd1);
    rd(3'd4, 16'h0000, "R10 read above span returns zero");
    idle();

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      mismatched++;
      compared++;
      $display("FAIL scoreboard (all requirements) actual=%0d expected=0 pending", exp_q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule